// File: doc/BRIEF.md
# Wide Vector Shift-Permute Unit

This block sits between two wide memory read ports and a compute pipeline. On each cycle it takes one byte vector, from either memory bank or from one of its own vector registers, and passes it through three operation slots in sequence within that cycle. Each slot can rotate the vector, broadcast one byte across it, compress byte pairs for pooling, swap bytes inside 4-byte groups, or merge it with a register vector under a byte mask held in another register. A slot can also pass the vector through unchanged.

The transformed vector is registered, so it appears on the output one cycle after the inputs. On the same clock edge it can be written into one of the four full-width vector registers. All registers can be read every cycle. A register read in the same cycle as a write to it returns the value it held before that write.

The vector width is a parameter, set to 128 bytes by default for simulation. The byte count must be a power of two, a multiple of 4, and at most 256. Byte 0 occupies bits [7:0].

Top module: `vsp_unit`

## Requirements
- R1: After a synchronous reset, `out_vec` is all zeros, `out_valid` is 0, and all four vector registers hold zero.
- R2: The result computed from the inputs at one rising edge appears on `out_vec` after that edge. `out_valid` at that point equals the `in_valid` that was sampled.
- R3: The 3-bit opcodes are: 0 pass, 1 rotate, 2 broadcast, 3 compress, 4 swap, 5 merge. Codes 6 and 7 also pass the vector through. Slot 1 is `slot_op[2:0]` with `slot_arg[7:0]`, and it runs first. Slot 2 uses the next 3-bit and 8-bit fields and runs second. Slot 3 uses the fields after that and runs last.
- R4: Rotate computes out[i] = in[(i+k) mod N], where k is the slot argument clamped to 64. This moves bytes toward lower indices.
- R5: Broadcast fills every byte with in[arg mod N], taken from the input of that slot.
- R6: Compress sets out[j] = unsigned max(in[2j], in[2j+1]) for j < N/2. The upper half of the result is zero.
- R7: Swap reverses the byte order inside each aligned 4-byte group: out[4g+b] = in[4g+3-b].
- R8: Merge sets out[i] = R_m[i] when R_k[i] is nonzero, and out[i] = in[i] otherwise. R_m is the register chosen by `mrg_reg` and R_k is the register chosen by `mask_reg`.
- R9: The source is chosen by `src_sel`: 0 selects bank A, 1 selects bank B, and 2 or 3 select the register chosen by `src_reg`.
- R10: When `in_valid` and `wr_en` are both high, the result is written to register `wr_dst` on the same edge that updates the output. No other register changes. When either signal is low, no register changes.
- R11: A register read in the same cycle as a write to that register returns the value it held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Inputs describe a valid operation |
| bank_a | input | NBYTES*8 | Vector from memory bank A |
| bank_b | input | NBYTES*8 | Vector from memory bank B |
| src_sel | input | 2 | Chain source: bank A, bank B, or register |
| src_reg | input | 2 | Register used as the source |
| mrg_reg | input | 2 | Register supplying merge data |
| mask_reg | input | 2 | Register supplying the merge byte mask |
| slot_op | input | 9 | Three 3-bit opcodes, slot 1 in the low bits |
| slot_arg | input | 24 | Three 8-bit arguments, slot 1 in the low bits |
| wr_en | input | 1 | Write the result to a register |
| wr_dst | input | 2 | Destination register |
| out_valid | output | 1 | Registered copy of in_valid |
| out_vec | output | NBYTES*8 | Registered transformed vector |

## Verification
The assertions check the following on every cycle:
- the one-cycle valid latency;
- that registers not addressed by a write hold their value;
- that a written register takes the written data;
- that a compress slot leaves its upper half zero;
- that a broadcast slot produces a uniform vector.

Other behaviours can only be shown by the bench's scenarios, because they depend on exact byte positions:
- rotation clamping at 64;
- broadcast index wrap;
- slot ordering, checked where two orderings give different results;
- merge selection by mask;
- read-before-write on the same register.

// File: rtl/vsp_pkg.sv
package vsp_pkg;

    localparam int OPW  = 3;
    localparam int ARGW = 8;

    typedef enum logic [OPW-1:0] {
        OP_PASS  = 3'd0,
        OP_ROT   = 3'd1,
        OP_BCAST = 3'd2,
        OP_CMPR  = 3'd3,
        OP_SWAP  = 3'd4,
        OP_MERGE = 3'd5
    } op_e;

    typedef struct packed {
        op_e             op;
        logic [ARGW-1:0] arg;
    } slot_t;

    typedef enum logic [1:0] {
        SRC_BANK_A = 2'd0,
        SRC_BANK_B = 2'd1,
        SRC_REG    = 2'd2
    } src_e;

    function automatic logic [7:0] umax8(input logic [7:0] a, input logic [7:0] b);
        return (a > b) ? a : b;
    endfunction

    function automatic int rot_amount(input logic [ARGW-1:0] arg, input int limit);
        return (int'(arg) > limit) ? limit : int'(arg);
    endfunction

endpackage

// File: rtl/vsp_stage.sv
module vsp_stage
    import vsp_pkg::*;
#(
    parameter int NBYTES  = 128,
    parameter int MAX_ROT = 64
) (
    input  logic                clk,
    input  logic                rst,
    input  slot_t               slot,
    input  logic [NBYTES*8-1:0] vec_in,
    input  logic [NBYTES*8-1:0] merge_vec,
    input  logic [NBYTES*8-1:0] mask_vec,
    output logic [NBYTES*8-1:0] vec_out
);
    localparam int W    = NBYTES * 8;
    localparam int IDXW = $clog2(NBYTES);
    localparam int HALF = NBYTES / 2;
    localparam int GRPS = NBYTES / 4;

    logic [W-1:0]    v_rot, v_bc, v_cmp, v_swp, v_mrg;
    logic [IDXW-1:0] bsel;
    logic [7:0]      bbyte;
    int              k;

    always_comb begin
        k = rot_amount(slot.arg, MAX_ROT);
        for (int i = 0; i < NBYTES; i++) begin
            v_rot[i*8 +: 8] = vec_in[((i + k) % NBYTES)*8 +: 8];
        end
    end

    assign bsel  = slot.arg[IDXW-1:0];
    assign bbyte = vec_in[int'(bsel)*8 +: 8];
    assign v_bc  = {NBYTES{bbyte}};

    always_comb begin
        v_cmp = '0;
        for (int j = 0; j < HALF; j++) begin
            v_cmp[j*8 +: 8] = umax8(vec_in[(2*j)*8 +: 8], vec_in[(2*j+1)*8 +: 8]);
        end
    end

    always_comb begin
        for (int g = 0; g < GRPS; g++) begin
            for (int b = 0; b < 4; b++) begin
                v_swp[(4*g+b)*8 +: 8] = vec_in[(4*g+3-b)*8 +: 8];
            end
        end
    end

    always_comb begin
        for (int i = 0; i < NBYTES; i++) begin
            v_mrg[i*8 +: 8] = (mask_vec[i*8 +: 8] != 8'd0) ? merge_vec[i*8 +: 8]
                                                             : vec_in[i*8 +: 8];
        end
    end

    always_comb begin
        case (slot.op)
            OP_ROT:   vec_out = v_rot;
            OP_BCAST: vec_out = v_bc;
            OP_CMPR:  vec_out = v_cmp;
            OP_SWAP:  vec_out = v_swp;
            OP_MERGE: vec_out = v_mrg;
            default:  vec_out = vec_in;
        endcase
    end

    // Assertion support: high when every output byte matches byte 0.
    logic out_uniform;
    always_comb begin
        out_uniform = 1'b1;
        for (int i = 1; i < NBYTES; i++) begin
            if (vec_out[i*8 +: 8] != vec_out[7:0]) out_uniform = 1'b0;
        end
    end

    assert_cmpr_upper_zero_R6: assert property (@(posedge clk) disable iff (rst)
        (slot.op == OP_CMPR) |-> (vec_out[W-1:W/2] == '0));

    assert_bcast_uniform_R5: assert property (@(posedge clk) disable iff (rst)
        (slot.op == OP_BCAST) |-> out_uniform);

endmodule

// File: rtl/vsp_regfile.sv
module vsp_regfile #(
    parameter int NBYTES = 128,
    parameter int NREGS  = 4,
    parameter int NRD    = 3,
    localparam int W     = NBYTES * 8,
    localparam int SELW  = $clog2(NREGS)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            we,
    input  logic [SELW-1:0] waddr,
    input  logic [W-1:0]    wdata,
    input  logic [SELW-1:0] rd_addr [NRD],
    output logic [W-1:0]    rd_data [NRD]
);
    logic [W-1:0] regs_q [NREGS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int r = 0; r < NREGS; r++) regs_q[r] <= '0;
        end else if (we) begin
            regs_q[waddr] <= wdata;
        end
    end

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        assign rd_data[p] = regs_q[rd_addr[p]];
    end

    for (genvar r = 0; r < NREGS; r++) begin : g_hold
        assert_unwritten_stable_R10: assert property (@(posedge clk) disable iff (rst)
            !(we && (waddr == SELW'(r))) |=> $stable(regs_q[r]));
    end

    assert_write_lands_R10: assert property (@(posedge clk) disable iff (rst)
        we |=> (regs_q[$past(waddr)] == $past(wdata)));

endmodule

// File: rtl/vsp_unit.sv
module vsp_unit
    import vsp_pkg::*;
#(
    parameter int NBYTES  = 128,
    parameter int NREGS   = 4,
    parameter int MAX_ROT = 64,
    parameter int NSLOTS  = 3,
    localparam int W      = NBYTES * 8,
    localparam int SELW   = $clog2(NREGS)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   in_valid,
    input  logic [W-1:0]           bank_a,
    input  logic [W-1:0]           bank_b,
    input  logic [1:0]             src_sel,
    input  logic [SELW-1:0]        src_reg,
    input  logic [SELW-1:0]        mrg_reg,
    input  logic [SELW-1:0]        mask_reg,
    input  logic [NSLOTS*OPW-1:0]  slot_op,
    input  logic [NSLOTS*ARGW-1:0] slot_arg,
    input  logic                   wr_en,
    input  logic [SELW-1:0]        wr_dst,
    output logic                   out_valid,
    output logic [W-1:0]           out_vec
);
    localparam int NRD = 3;

    logic [SELW-1:0] rd_addr [NRD];
    logic [W-1:0]    rd_data [NRD];
    logic [W-1:0]    chain   [NSLOTS+1];
    slot_t           slots   [NSLOTS];
    logic            we;

    assign rd_addr[0] = src_reg;
    assign rd_addr[1] = mrg_reg;
    assign rd_addr[2] = mask_reg;
    assign we         = in_valid & wr_en;

    vsp_regfile #(.NBYTES(NBYTES), .NREGS(NREGS), .NRD(NRD)) u_regs (
        .clk(clk), .rst(rst), .we(we), .waddr(wr_dst), .wdata(chain[NSLOTS]),
        .rd_addr(rd_addr), .rd_data(rd_data)
    );

    always_comb begin
        case (src_e'(src_sel))
            SRC_BANK_A: chain[0] = bank_a;
            SRC_BANK_B: chain[0] = bank_b;
            default:    chain[0] = rd_data[0];
        endcase
    end

    for (genvar s = 0; s < NSLOTS; s++) begin : g_slot
        assign slots[s].op  = op_e'(slot_op[s*OPW +: OPW]);
        assign slots[s].arg = slot_arg[s*ARGW +: ARGW];

        vsp_stage #(.NBYTES(NBYTES), .MAX_ROT(MAX_ROT)) u_stage (
            .clk(clk), .rst(rst), .slot(slots[s]), .vec_in(chain[s]),
            .merge_vec(rd_data[1]), .mask_vec(rd_data[2]), .vec_out(chain[s+1])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_vec   <= '0;
        end else begin
            out_valid <= in_valid;
            out_vec   <= chain[NSLOTS];
        end
    end

    assert_valid_follows_R2: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    assert_idle_follows_R2: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

endmodule

// File: tb/vsp_unit_bench.sv
module vsp_unit_bench;
    localparam int N = 128;
    localparam int W = N * 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic [W-1:0] bank_a = '0, bank_b = '0;
    logic [1:0]   src_sel = '0, src_reg = '0, mrg_reg = '0, mask_reg = '0, wr_dst = '0;
    logic [8:0]   slot_op = '0;
    logic [23:0]  slot_arg = '0;
    logic         wr_en = 1'b0;
    logic         out_valid;
    logic [W-1:0] out_vec;

    int n_checks = 0, n_fail = 0;
    bit [W-1:0] mreg [4];

    always #2 clk = ~clk;

    vsp_unit u_vsp_unit (
        .clk(clk), .rst(rst), .in_valid(in_valid), .bank_a(bank_a), .bank_b(bank_b),
        .src_sel(src_sel), .src_reg(src_reg), .mrg_reg(mrg_reg), .mask_reg(mask_reg),
        .slot_op(slot_op), .slot_arg(slot_arg), .wr_en(wr_en), .wr_dst(wr_dst),
        .out_valid(out_valid), .out_vec(out_vec)
    );

    function automatic bit [W-1:0] m_slot(bit [W-1:0] v, bit [2:0] op, bit [7:0] arg,
                                          bit [W-1:0] mv, bit [W-1:0] kv);
        bit [W-1:0] r;
        int k;
        r = v;
        case (op)
            3'd1: begin
                k = (arg > 64) ? 64 : int'(arg);
                for (int i = 0; i < N; i++) r[i*8 +: 8] = v[((i + k) % N)*8 +: 8];
            end
            3'd2: for (int i = 0; i < N; i++) r[i*8 +: 8] = v[(int'(arg) % N)*8 +: 8];
            3'd3: begin
                r = '0;
                for (int j = 0; j < N/2; j++) begin
                    r[j*8 +: 8] = (v[(2*j)*8 +: 8] > v[(2*j+1)*8 +: 8]) ?
                                  v[(2*j)*8 +: 8] : v[(2*j+1)*8 +: 8];
                end
            end
            3'd4: for (int i = 0; i < N; i++) r[i*8 +: 8] = v[((i/4)*4 + 3 - i%4)*8 +: 8];
            3'd5: for (int i = 0; i < N; i++)
                      r[i*8 +: 8] = (kv[i*8 +: 8] != 0) ? mv[i*8 +: 8] : v[i*8 +: 8];
            default: r = v;
        endcase
        return r;
    endfunction

    function automatic bit [W-1:0] rnd_vec(int zero_pct);
        bit [W-1:0] r;
        for (int i = 0; i < N; i++) begin
            r[i*8 +: 8] = 8'($urandom_range(0, 255));
            if ($urandom_range(0, 99) < zero_pct) r[i*8 +: 8] = 8'd0;
        end
        return r;
    endfunction

    task automatic check(input bit ok, input string tag, input bit [W-1:0] act, input bit [W-1:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Called just after a falling edge; returns just after the next falling edge.
    task automatic do_op(input bit [1:0] src, input bit [1:0] sr, input bit [1:0] mr,
                         input bit [1:0] kr, input bit [8:0] ops, input bit [23:0] args,
                         input bit iv, input bit we, input bit [1:0] dst, input string tag);
        bit [W-1:0] v;
        v = (src == 0) ? bank_a : (src == 1) ? bank_b : mreg[sr];
        for (int s = 0; s < 3; s++)
            v = m_slot(v, ops[s*3 +: 3], args[s*8 +: 8], mreg[mr], mreg[kr]);
        src_sel = src; src_reg = sr; mrg_reg = mr; mask_reg = kr;
        slot_op = ops; slot_arg = args; in_valid = iv; wr_en = we; wr_dst = dst;
        @(posedge clk);
        if (iv && we) mreg[dst] = v;
        @(negedge clk);
        check(out_valid == iv, {tag, " valid"}, W'(out_valid), W'(iv));
        check(out_vec == v, tag, out_vec, v);
    endtask

    // Read back register r through the pass-through path (R10/R1 observation).
    task automatic peek(input bit [1:0] r, input string tag);
        do_op(2'd2, r, 2'd0, 2'd0, 9'd0, 24'd0, 1'b1, 1'b0, 2'd0, tag);
    endtask

    initial begin
        #(4 * 200000);
        n_checks++; n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        bit [W-1:0] pat;
        void'($urandom(32'd7719));
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        check(out_vec == '0, "R1 out_vec", out_vec, '0);
        check(out_valid == 1'b0, "R1 out_valid", W'(out_valid), '0);
        rst = 1'b0;
        for (int r = 0; r < 4; r++) peek(2'(r), "R1 reg zero");

        // R9 source selection, R10 writes
        bank_a = rnd_vec(0); bank_b = rnd_vec(0);
        do_op(2'd0, 0, 0, 0, 9'd0, 24'd0, 1, 1, 2'd0, "R9 bank A");
        do_op(2'd1, 0, 0, 0, 9'd0, 24'd0, 1, 1, 2'd1, "R9 bank B");
        do_op(2'd3, 2'd1, 0, 0, 9'd0, 24'd0, 1, 0, 2'd2, "R9 reg src");

        // R4 rotate amounts including clamp
        pat = '0;
        for (int i = 0; i < N; i++) pat[i*8 +: 8] = 8'(i);
        bank_a = pat;
        do_op(0, 0, 0, 0, 9'd1, 24'd0,   1, 0, 0, "R4 rot 0");
        do_op(0, 0, 0, 0, 9'd1, 24'd1,   1, 0, 0, "R4 rot 1");
        do_op(0, 0, 0, 0, 9'd1, 24'd64,  1, 0, 0, "R4 rot 64");
        do_op(0, 0, 0, 0, 9'd1, 24'd65,  1, 0, 0, "R4 rot clamp 65");
        do_op(0, 0, 0, 0, 9'd1, 24'd200, 1, 0, 0, "R4 rot clamp 200");

        // R5 broadcast incl. index wrap
        do_op(0, 0, 0, 0, 9'd2, 24'd0,   1, 0, 0, "R5 bcast 0");
        do_op(0, 0, 0, 0, 9'd2, 24'd127, 1, 0, 0, "R5 bcast top");
        do_op(0, 0, 0, 0, 9'd2, 24'd200, 1, 0, 0, "R5 bcast wrap");

        // R6 compress, R7 swap
        bank_a = rnd_vec(20);
        do_op(0, 0, 0, 0, 9'd3, 24'd0, 1, 0, 0, "R6 compress");
        do_op(0, 0, 0, 0, 9'd4, 24'd0, 1, 0, 0, "R7 swap");
        do_op(0, 0, 0, 0, {3'd0, 3'd4, 3'd4}, 24'd0, 1, 0, 0, "R7 double swap");

        // R3 ordering and unused codes
        bank_a = pat;
        do_op(0, 0, 0, 0, {3'd0, 3'd3, 3'd1}, 24'h00_00_05, 1, 0, 0, "R3 rot then cmpr");
        do_op(0, 0, 0, 0, {3'd0, 3'd1, 3'd3}, 24'h00_05_00, 1, 0, 0, "R3 cmpr then rot");
        do_op(0, 0, 0, 0, {3'd7, 3'd6, 3'd0}, 24'hFF_FF_FF, 1, 0, 0, "R3 codes 6/7 pass");

        // R8 merge: mask all zero, all nonzero, mixed
        bank_a = '0;
        do_op(0, 0, 0, 0, 9'd0, 24'd0, 1, 1, 2'd3, "R8 load zero mask");
        bank_a = rnd_vec(0); bank_b = rnd_vec(0);
        do_op(1, 0, 0, 0, 9'd0, 24'd0, 1, 1, 2'd2, "R8 load merge data");
        do_op(0, 0, 2'd2, 2'd3, 9'd5, 24'd0, 1, 0, 0, "R8 mask zero");
        do_op(0, 0, 2'd2, 2'd1, 9'd5, 24'd0, 1, 0, 0, "R8 mask full");
        bank_b = rnd_vec(50);
        do_op(1, 0, 0, 0, 9'd0, 24'd0, 1, 1, 2'd3, "R8 load mixed mask");
        do_op(0, 0, 2'd2, 2'd3, 9'd5, 24'd0, 1, 0, 0, "R8 mask mixed");

        // R10 no write when wr_en or in_valid low
        bank_a = rnd_vec(0);
        do_op(0, 0, 0, 0, 9'd0, 24'd0, 1, 0, 2'd0, "R10 wr_en low");
        peek(2'd0, "R10 reg0 kept");
        do_op(0, 0, 0, 0, 9'd0, 24'd0, 0, 1, 2'd0, "R2 R10 in_valid low");
        peek(2'd0, "R10 reg0 kept idle");
        for (int r = 1; r < 4; r++) peek(2'(r), "R10 others kept");

        // R11 read of register being written returns old value
        do_op(2'd2, 2'd1, 0, 0, 9'd4, 24'd0, 1, 1, 2'd1, "R11 rd-wr same reg");
        peek(2'd1, "R11 reg1 updated");

        // Random mix (R2 R3 R4 R5 R6 R7 R8 R9 R10)
        for (int t = 0; t < 300; t++) begin
            bit [8:0] ops;
            bank_a = rnd_vec(25); bank_b = rnd_vec(25);
            for (int s = 0; s < 3; s++) ops[s*3 +: 3] = 3'($urandom_range(0, 7));
            do_op(2'($urandom_range(0, 3)), 2'($urandom_range(0, 3)), 2'($urandom_range(0, 3)),
                  2'($urandom_range(0, 3)), ops, 24'($urandom),
                  1'($urandom_range(0, 7) != 0), 1'($urandom_range(0, 1)),
                  2'($urandom_range(0, 3)), "R3 random chain");
        end
        for (int r = 0; r < 4; r++) peek(2'(r), "R10 final regs");

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule